// File: doc/BRIEF.md
# Prioritized Bridge Interrupt Collector

This block gathers interrupt requests from the far side of a bus bridge. It handles seven prioritized bus levels, a bus-ownership event and a small group of special events such as DMA completion and error reports. It drives a single interrupt line to the host. Every source has an enable bit and a sticky status bit. Each bus level also keeps a capture register that holds the vector ID and the error flag presented when the level's event was accepted.

Software reads the highest pending level from a dedicated output. It can then drop the enables of that level and every level below it, so that only higher levels can interrupt while the handler runs. The masked status bits stay set until software writes ones to clear them. While a level's status bit is set, that level accepts no new event, so its capture register cannot be overwritten before it has been read.

Host access uses a plain 32-bit register port: a one-cycle write strobe with address and data, and a read data bus that follows the address combinationally. The event inputs are single-cycle pulses with no handshake, so the block never applies back-pressure. Each event is accepted or dropped in the cycle it arrives.

Top module: `bic_top`

## Requirements
- R1: A status bit is set by its event pulse only when its enable bit is 1 at the clock edge where the pulse is sampled. A pulse that arrives while the source is disabled is dropped and leaves no trace.
- R2: `irq_out` is high exactly when some bit is 1 in both the status and the enable register. Clearing an enable bit masks a status bit without clearing it.
- R3: The status and enable bit layout is as follows. Bit 0 is the bus-ownership event. Bits 1 to 7 are bus levels 1 to 7, so `lvl_evt[i]` is level i+1. Bits 8 to 10 are the special events `spc_evt[0..2]`, and DMA done is `spc_evt[0]` at bit 8.
- R4: `top_lvl` gives the number (1 to 7) of the highest bus level that has both its status and enable bits set. Level 7 ranks highest. A value of 0 means no bus level is pending, even when ownership or special events are pending.
- R5: A write to byte address 0x04 clears every status bit whose data bit is 1 and leaves the others unchanged. A read of 0x04 returns the status in bits 10:0.
- R6: The capture register of level L sits at byte address 0x10 + 4*(L-1). It returns the accepted ID in bits 7:0 and the error flag in bit 31. It is loaded from that level's `lvl_id`/`lvl_err` slices when the level's event is accepted.
- R7: While a level's status bit is set, a new event at that level is not accepted. The status bit stays set and the capture register keeps its earlier contents.
- R8: Reset clears the enable, status and capture registers and holds `irq_out` and `top_lvl` at 0.
- R9: The enable register is read and written at byte address 0x00 using bits 10:0. Its upper bits read as 0, and any unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| own_evt | input | 1 | Bus-ownership event pulse |
| lvl_evt | input | 7 | Bus level event pulses, bit i is level i+1 |
| lvl_id | input | 56 | Per-level vector ID, 8 bits per level, level 1 in bits 7:0 |
| lvl_err | input | 7 | Per-level error flag from the acknowledge cycle |
| spc_evt | input | 3 | Special event pulses, bit 0 is DMA done |
| irq_out | output | 1 | Interrupt line to the host |
| top_lvl | output | 3 | Highest pending bus level, 0 when none |

## Verification
All seven levels are pulsed at once under each of the 128 level-enable patterns. This separates enabled from disabled levels, checks the priority encoder against the highest set bit of every pattern, and shows each enabled level capturing its own ID rather than a neighbour's. Repeated pulses on a level whose status is still set show whether a pending event is protected or overwritten. Masking tests show whether a cleared enable hides a status bit or erases it. Partial and all-zero clear writes, ownership and special events with no level pending, and reads of the enable register, unmapped addresses and reset state cover the remaining register-port behaviour.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int unsigned OFS_EN   = 8'h00;
  localparam int unsigned OFS_ST   = 8'h04;
  localparam int unsigned OFS_CAP0 = 8'h10;
  localparam int unsigned CAP_STEP = 4;
  localparam int unsigned ERR_BIT  = 31;
  localparam int unsigned DW       = 32;
endpackage

// File: rtl/bic_status.sv
module bic_status #(
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic          clr_wr,
  input  logic [SW-1:0] wdata,
  input  logic [SW-1:0] evt,
  output logic [SW-1:0] en_q,
  output logic [SW-1:0] stat_q,
  output logic [SW-1:0] accept
);
  logic [SW-1:0] clr_mask;

  // an event is taken only when enabled and not already pending
  assign accept   = evt & en_q & ~stat_q;
  assign clr_mask = clr_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata;
      stat_q <= (stat_q & ~clr_mask) | accept;
    end
  end
endmodule

// File: rtl/bic_capture.sv
module bic_capture #(
  parameter int NLVL = 7,
  parameter int IDW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NLVL-1:0]      take,
  input  logic [NLVL*IDW-1:0]  id_in,
  input  logic [NLVL-1:0]      err_in,
  output logic [NLVL*IDW-1:0]  cap_id,
  output logic [NLVL-1:0]      cap_err
);
  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_id[l*IDW +: IDW] <= '0;
        cap_err[l]           <= 1'b0;
      end else if (take[l]) begin
        cap_id[l*IDW +: IDW] <= id_in[l*IDW +: IDW];
        cap_err[l]           <= err_in[l];
      end
    end
  end
endmodule

// File: rtl/bic_prio.sv
module bic_prio #(
  parameter int NLVL = 7,
  localparam int LW  = $clog2(NLVL + 1)
) (
  input  logic [NLVL-1:0] pend,
  output logic [LW-1:0]   lvl
);
  // scanning upward, the last hit is the highest level
  always_comb begin
    lvl = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (pend[i]) lvl = LW'(i + 1);
    end
  end
endmodule

// File: rtl/bic_top.sv
module bic_top
  import bic_pkg::*;
#(
  parameter int NLVL = 7,
  parameter int NSPC = 3,
  parameter int IDW  = 8,
  parameter int ADW  = 8,
  localparam int SW  = NLVL + 1 + NSPC,
  localparam int LW  = $clog2(NLVL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADW-1:0]      reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic                own_evt,
  input  logic [NLVL-1:0]     lvl_evt,
  input  logic [NLVL*IDW-1:0] lvl_id,
  input  logic [NLVL-1:0]     lvl_err,
  input  logic [NSPC-1:0]     spc_evt,
  output logic                irq_out,
  output logic [LW-1:0]       top_lvl
);
  logic [SW-1:0]       evt_vec;
  logic [SW-1:0]       en_q;
  logic [SW-1:0]       stat_q;
  logic [SW-1:0]       accept;
  logic [NLVL*IDW-1:0] cap_id;
  logic [NLVL-1:0]     cap_err;
  logic                en_wr;
  logic                clr_wr;

  assign evt_vec = {spc_evt, lvl_evt, own_evt};
  assign en_wr   = reg_wr && (int'(reg_addr) == OFS_EN);
  assign clr_wr  = reg_wr && (int'(reg_addr) == OFS_ST);

  bic_status #(.SW(SW)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_wr  (en_wr),
    .clr_wr (clr_wr),
    .wdata  (reg_wdata[SW-1:0]),
    .evt    (evt_vec),
    .en_q   (en_q),
    .stat_q (stat_q),
    .accept (accept)
  );

  bic_capture #(.NLVL(NLVL), .IDW(IDW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (accept[NLVL:1]),
    .id_in   (lvl_id),
    .err_in  (lvl_err),
    .cap_id  (cap_id),
    .cap_err (cap_err)
  );

  bic_prio #(.NLVL(NLVL)) u_prio (
    .pend (stat_q[NLVL:1] & en_q[NLVL:1]),
    .lvl  (top_lvl)
  );

  assign irq_out = |(stat_q & en_q);

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == OFS_EN) reg_rdata[SW-1:0] = en_q;
    if (int'(reg_addr) == OFS_ST) reg_rdata[SW-1:0] = stat_q;
    for (int l = 0; l < NLVL; l++) begin
      if (int'(reg_addr) == OFS_CAP0 + CAP_STEP * l) begin
        reg_rdata[IDW-1:0] = cap_id[l*IDW +: IDW];
        reg_rdata[ERR_BIT] = cap_err[l];
      end
    end
  end
endmodule

// File: rtl/bic_chk.sv
module bic_chk
  import bic_pkg::*;
#(
  parameter int NLVL = 7,
  parameter int IDW  = 8,
  parameter int SW   = 11,
  parameter int ADW  = 8,
  parameter int LW   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADW-1:0]      reg_addr,
  input logic [DW-1:0]       reg_wdata,
  input logic [SW-1:0]       en_q,
  input logic [SW-1:0]       stat_q,
  input logic [NLVL*IDW-1:0] cap_id,
  input logic                irq_out,
  input logic [LW-1:0]       top_lvl
);
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(en_q)) == '0); // R1

  AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out); // R2

  AST_TOP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (top_lvl != '0) |-> (stat_q[top_lvl] && en_q[top_lvl])); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr) && (int'($past(reg_addr)) == OFS_ST)) |->
      ((stat_q & $past(reg_wdata[SW-1:0] & stat_q)) == '0)); // R5

  for (genvar l = 0; l < NLVL; l++) begin : g_hold
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stat_q[l+1]) |-> $stable(cap_id[l*IDW +: IDW])); // R7
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq_out && top_lvl == '0)); // R8
endmodule

bind bic_top bic_chk #(
  .NLVL(NLVL), .IDW(IDW), .SW(SW), .ADW(ADW), .LW(LW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .en_q      (en_q),
  .stat_q    (stat_q),
  .cap_id    (cap_id),
  .irq_out   (irq_out),
  .top_lvl   (top_lvl)
);

// File: tb/tb_bic_top.sv
`timescale 1ns/1ps
module tb_bic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        own_evt = 1'b0;
  logic [6:0]  lvl_evt = '0;
  logic [55:0] lvl_id = '0;
  logic [6:0]  lvl_err = '0;
  logic [2:0]  spc_evt = '0;
  logic        irq_out;
  logic [2:0]  top_lvl;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bic_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .own_evt(own_evt),
    .lvl_evt(lvl_evt), .lvl_id(lvl_id), .lvl_err(lvl_err),
    .spc_evt(spc_evt), .irq_out(irq_out), .top_lvl(top_lvl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic pulse(input logic o, input logic [6:0] l, input logic [2:0] s);
    @(negedge clk);
    own_evt = o; lvl_evt = l; spc_evt = s;
    @(negedge clk);
    own_evt = 1'b0; lvl_evt = '0; spc_evt = '0;
  endtask

  function automatic logic [7:0] id_of(int lvl, int p);
    return 8'((lvl * 17 + p * 3) & 8'hff);
  endfunction

  function automatic logic [31:0] hi_lvl(int p);
    logic [31:0] h = 0;
    for (int i = 0; i < 7; i++) if (p[i]) h = i + 1;
    return h;
  endfunction

  initial begin
    #750000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 irq", {31'd0, irq_out}, 0);
    check("R8 top", {29'd0, top_lvl}, 0);
    rst_n = 1'b1;
    rd(8'h00, d); check("R8 enable", d, 0);
    rd(8'h04, d); check("R8 status", d, 0);
    for (int l = 1; l <= 7; l++) begin
      rd(8'(16 + 4 * (l - 1)), d); check("R8 capture", d, 0);
    end

    // R1 R3 R4 R5 R6: sweep every level-enable pattern
    for (int p = 0; p < 128; p++) begin
      wr(8'h00, 32'(p) << 1);
      for (int l = 1; l <= 7; l++) begin
        lvl_id[(l-1)*8 +: 8] = id_of(l, p);
        lvl_err[l-1] = ((l + p) % 3) == 0;
      end
      pulse(1'b0, 7'h7f, 3'b000);
      rd(8'h04, d); check("R1 status", d, 32'(p) << 1);
      check("R4 top", {29'd0, top_lvl}, hi_lvl(p));
      check("R2 irq", {31'd0, irq_out}, (p != 0) ? 1 : 0);
      for (int l = 1; l <= 7; l++) begin
        if (p[l-1]) begin
          rd(8'(16 + 4 * (l - 1)), d);
          check("R6 capture", d,
                {(((l + p) % 3) == 0) ? 1'b1 : 1'b0, 23'd0, id_of(l, p)});
        end
      end
      wr(8'h04, 32'h0000_07ff);
      rd(8'h04, d); check("R5 clear all", d, 0);
    end

    // R7: pending level rejects new events and keeps its capture
    wr(8'h00, 32'h0000_0008);
    lvl_id[16 +: 8] = 8'hA5; lvl_err[2] = 1'b0;
    pulse(1'b0, 7'h04, 3'b000);
    lvl_id[16 +: 8] = 8'h3C; lvl_err[2] = 1'b1;
    pulse(1'b0, 7'h04, 3'b000);
    rd(8'h18, d); check("R7 kept", d, 32'h0000_00A5);
    rd(8'h04, d); check("R7 status", d, 32'h0000_0008);
    wr(8'h04, 32'h0000_0008);
    pulse(1'b0, 7'h04, 3'b000);
    rd(8'h18, d); check("R7 reaccept", d, 32'h8000_003C);

    // R5: zero bits leave status alone, partial clear
    wr(8'h00, 32'h0000_07ff);
    pulse(1'b1, 7'h7f, 3'b111);
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, d); check("R5 zero write", d, 32'h0000_07ff);
    wr(8'h04, 32'h0000_0155);
    rd(8'h04, d); check("R5 partial", d, 32'h0000_06aa);
    wr(8'h04, 32'hffff_ffff);

    // R2: masking keeps status
    wr(8'h00, 32'h0000_0120);
    pulse(1'b0, 7'h10, 3'b001);
    check("R2 irq on", {31'd0, irq_out}, 1);
    check("R4 top5", {29'd0, top_lvl}, 5);
    wr(8'h00, 32'h0000_0000);
    check("R2 irq masked", {31'd0, irq_out}, 0);
    check("R4 masked top", {29'd0, top_lvl}, 0);
    rd(8'h04, d); check("R2 status kept", d, 32'h0000_0120);
    wr(8'h00, 32'h0000_0100);
    check("R2 unmask", {31'd0, irq_out}, 1);
    wr(8'h04, 32'h0000_0120);

    // R3: ownership and special sources only
    wr(8'h00, 32'h0000_0701);
    pulse(1'b1, 7'h00, 3'b101);
    rd(8'h04, d); check("R3 layout", d, 32'h0000_0501);
    check("R3 top zero", {29'd0, top_lvl}, 0);
    check("R3 irq", {31'd0, irq_out}, 1);
    wr(8'h04, 32'h0000_0501);
    check("R2 irq off", {31'd0, irq_out}, 0);

    // R1: disabled pulse then enable: event lost
    wr(8'h00, 32'h0);
    pulse(1'b1, 7'h7f, 3'b111);
    wr(8'h00, 32'h0000_07ff);
    rd(8'h04, d); check("R1 lost", d, 0);
    check("R1 irq", {31'd0, irq_out}, 0);

    // R9: enable width and unmapped reads
    wr(8'h00, 32'hffff_ffff);
    rd(8'h00, d); check("R9 enable", d, 32'h0000_07ff);
    rd(8'h0C, d); check("R9 unmapped", d, 0);
    rd(8'h2C, d); check("R9 past last", d, 0);

    // R8: reset mid-run
    wr(8'h00, 32'h0000_0002);
    pulse(1'b0, 7'h01, 3'b000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R8 irq rst", {31'd0, irq_out}, 0);
    rst_n = 1'b1;
    rd(8'h04, d); check("R8 status rst", d, 0);
    rd(8'h10, d); check("R8 cap rst", d, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule